// File: doc/BRIEF.md
# Pin Open/Short Test Sequencer

This block runs a continuity test on the protection diode pair of every pin of a device under test. It works on one pin at a time. For each pin it first checks the diode to the positive rail by asking an external force/measure unit for a positive-current measurement. It then checks the diode to the negative rail with a negative-current measurement. The pin under test is routed to the force unit. All other pins are held at ground, and the supply rails are held at ground for the whole run.

The force/measure unit is driven through a request/ready handshake. Once the request is accepted, the unit returns a signed reading in millivolts with a one-cycle valid strobe. Each reading is sorted into pass, open or short using a window that depends on the polarity. The verdict goes into a two-bit field kept per pin and per polarity. After the last pin, a done flag rises, and a sticky fail flag shows whether any field holds something other than pass. If the unit stalls, a timeout aborts the run and marks the pin that hung.

Top module: `pin_os_seq`

## Requirements
- R1: A run tests pins in ascending order starting from pin 0. Each pin gets exactly two measurements: first positive (force_pol = 0), then negative (force_pol = 1). While busy, pin_sel is one-hot on the pin under test.
- R2: While busy, pin_gnd equals the bitwise inverse of pin_sel and rail_gnd is 1. While idle, pin_gnd is all ones, pin_sel is 0 and rail_gnd is 0.
- R3: A positive-polarity reading above +1500 mV gives code 01 (open), and a reading below +200 mV gives code 10 (short). Any other reading, including both boundary values, gives 00 (pass).
- R4: A negative-polarity reading above -200 mV gives code 10 (short), and a reading below -1500 mV gives code 01 (open). Any other reading, including both boundary values, gives 00 (pass).
- R5: force_req rises on the cycle after the run start or after the previous reading is taken. It stays high, with pin_sel and force_pol unchanged, until force_rdy is sampled high. A meas_valid pulse that arrives before the request is accepted is ignored.
- R6: For pin p, the positive verdict is held in results[4p+1:4p] and the negative verdict in results[4p+3:4p+2]. A field updates on the edge that samples its reading. All fields clear to 00 when a run starts.
- R7: One cycle after the last pin's negative reading is sampled, busy falls and done rises. done stays high until the next accepted run_start.
- R8: any_fail is 1 exactly when at least one result field of the current run is non-zero.
- R9: A measurement times out when TIMEOUT_CYC cycles pass from the rise of force_req without its reading being taken. On timeout the field under test gets code 11, timeout_err rises, err_pin holds the pin index, and the run ends with done high and busy low.
- R10: run_start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Pulse that starts a test run when idle |
| force_rdy | input | 1 | Force unit accepts the current request |
| meas_valid | input | 1 | Reading on meas_mv is valid this cycle |
| meas_mv | input | MEAS_W | Signed measured voltage in millivolts |
| busy | output | 1 | Run in progress |
| force_req | output | 1 | Request a measurement from the force unit |
| force_pol | output | 1 | Polarity of the forced current: 0 positive, 1 negative |
| pin_sel | output | NUM_PINS | One-hot route of the pin under test to the force unit |
| pin_gnd | output | NUM_PINS | Per-pin ground clamp |
| rail_gnd | output | 1 | Ground both supply rails |
| done | output | 1 | Run finished (normally or by timeout) |
| any_fail | output | 1 | Some result field is not pass |
| timeout_err | output | 1 | Run was aborted by a timeout |
| err_pin | output | PIN_W | Pin under test when the timeout hit |
| results | output | 4*NUM_PINS | Verdict fields, two bits per pin per polarity |

## Verification
The bench sets readings exactly on each of the four limits and one millivolt outside them. A design with a flipped or non-inclusive compare would mark a good boundary diode as open or short, and a design that swapped the polarity windows would report shorts on every healthy pin. It also pulses meas_valid while a request is still pending and pulses run_start in the middle of a run. A design that took the early strobe would store a bogus verdict, and one that restarted would clear fields that were already recorded. Two timeout runs stall once at the ready stage and once at the valid stage. A timer that restarted at acceptance, or an abort that failed to mark the field, would show a late timeout or a missing error code.

// File: rtl/pin_os_pkg.sv
// Shared types of the pin open/short sequencer.
// Assumes: a two-bit verdict code, where the open and short codes are
// fixed by the result field layout read by the user.
package pin_os_pkg;

    typedef enum logic [1:0] {
        RES_PASS  = 2'b00,
        RES_OPEN  = 2'b01,
        RES_SHORT = 2'b10,
        RES_ERR   = 2'b11
    } res_code_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pin_os_classify.sv
// Sorts one signed millivolt reading into pass/open/short.
// Assumes: the limits are inclusive pass boundaries. Positive polarity:
// open above POS_OPEN_MV, short below POS_SHORT_MV. Negative polarity:
// short above NEG_SHORT_MV, open below NEG_OPEN_MV.
module pin_os_classify
    import pin_os_pkg::*;
#(
    parameter int MEAS_W       = 16,
    parameter int POS_OPEN_MV  = 1500,
    parameter int POS_SHORT_MV = 200,
    parameter int NEG_SHORT_MV = -200,
    parameter int NEG_OPEN_MV  = -1500
) (
    input  logic [MEAS_W-1:0] meas_mv,
    input  logic              neg_pol,
    output res_code_t         code
);

    logic signed [31:0] val;

    // Sign-extend the reading for comparison with the integer limits.
    always_comb val = 32'(signed'(meas_mv));

    // Pick the window that matches the forced polarity.
    always_comb begin
        code = RES_PASS;
        if (!neg_pol) begin
            if (val > POS_OPEN_MV)       code = RES_OPEN;
            else if (val < POS_SHORT_MV) code = RES_SHORT;
        end else begin
            if (val > NEG_SHORT_MV)      code = RES_SHORT;
            else if (val < NEG_OPEN_MV)  code = RES_OPEN;
        end
    end

endmodule

// File: rtl/pin_os_timer.sv
// Watchdog timer for one measurement, from request to reading.
// Assumes: clr has priority over run. expired stays high once the count
// reaches TIMEOUT_CYC-1, and the count saturates at TIMEOUT_CYC.
module pin_os_timer #(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count the cycles spent on the current measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (clr)                                cnt_q <= '0;
        else if (run && cnt_q != CNT_W'(TIMEOUT_CYC)) cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last allowed cycle.
    always_comb expired = (cnt_q >= CNT_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/pin_os_results.sv
// Verdict storage: one two-bit field per pin per polarity, plus a sticky
// fail flag. Field index = 2*pin + polarity.
// Assumes: clr and wr_en are never high in the same cycle.
module pin_os_results
    import pin_os_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [FLD_W-1:0]        wr_idx,
    input  res_code_t               wr_code,
    output logic [4*NUM_PINS-1:0]   results,
    output logic                    any_fail
);

    localparam int NUM_FLD = 2 * NUM_PINS;
    localparam int FLD_W   = $clog2(NUM_FLD);

    logic fail_q;

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        logic [1:0] fld_q;

        // Hold one verdict; clear on run start, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   fld_q <= 2'b00;
            else if (clr)                                 fld_q <= 2'b00;
            else if (wr_en && wr_idx == FLD_W'(f))        fld_q <= wr_code;
        end

        assign results[2*f +: 2] = fld_q;
    end

    // Remember whether any verdict of this run is not a pass.
    always_ff @(posedge clk) begin
        if (!rst_n)                             fail_q <= 1'b0;
        else if (clr)                           fail_q <= 1'b0;
        else if (wr_en && wr_code != RES_PASS)  fail_q <= 1'b1;
    end

    assign any_fail = fail_q;

endmodule

// File: rtl/pin_os_ctrl.sv
// Run sequencer: walks the pins in order, issuing a positive and then a
// negative measurement request on each, and drives the routing clamps.
// Assumes: force_rdy is only meaningful while force_req is high, and
// meas_valid only after the request has been accepted.
module pin_os_ctrl
    import pin_os_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_start,
    input  logic                force_rdy,
    input  logic                meas_valid,
    input  logic                tmr_expired,
    output logic                busy,
    output logic                force_req,
    output logic                force_pol,
    output logic [NUM_PINS-1:0] pin_sel,
    output logic [NUM_PINS-1:0] pin_gnd,
    output logic                rail_gnd,
    output logic                tmr_clr,
    output logic                tmr_run,
    output logic                res_clr,
    output logic                wr_en,
    output logic                wr_err,
    output logic [FLD_W-1:0]    wr_idx,
    output logic                done,
    output logic                timeout_err,
    output logic [PIN_W-1:0]    err_pin
);

    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int FLD_W = $clog2(2 * NUM_PINS);
    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    seq_state_t       state_q;
    logic [PIN_W-1:0] pin_q;
    logic             pol_q;
    logic             done_q;
    logic             to_q;
    logic [PIN_W-1:0] err_pin_q;
    logic             accept;
    logic             abort;

    // Decode the events of this cycle: reading taken or measurement timed out.
    always_comb begin
        accept = (state_q == ST_WAIT) && meas_valid;
        abort  = tmr_expired &&
                 (((state_q == ST_REQ) && !force_rdy) ||
                  ((state_q == ST_WAIT) && !meas_valid));
    end

    // Step through request, wait, pin and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pin_q     <= '0;
            pol_q     <= 1'b0;
            done_q    <= 1'b0;
            to_q      <= 1'b0;
            err_pin_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run_start) begin
                        state_q   <= ST_REQ;
                        pin_q     <= '0;
                        pol_q     <= 1'b0;
                        done_q    <= 1'b0;
                        to_q      <= 1'b0;
                        err_pin_q <= '0;
                    end
                end
                ST_REQ: begin
                    if (force_rdy) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (accept) begin
                        state_q <= ST_REQ;
                        if (!pol_q) begin
                            pol_q <= 1'b1;
                        end else if (pin_q == LAST_PIN) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            pin_q <= pin_q + 1'b1;
                            pol_q <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (abort) begin
                state_q   <= ST_IDLE;
                done_q    <= 1'b1;
                to_q      <= 1'b1;
                err_pin_q <= pin_q;
            end
        end
    end

    // Drive the force unit, the routing clamps and the side controls.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        force_req = (state_q == ST_REQ);
        force_pol = busy && pol_q;
        pin_sel   = busy ? (NUM_PINS'(1) << pin_q) : '0;
        pin_gnd   = ~pin_sel;
        rail_gnd  = busy;
        tmr_clr   = (state_q == ST_IDLE) || accept;
        tmr_run   = !tmr_clr;
        res_clr   = (state_q == ST_IDLE) && run_start;
        wr_en     = accept || abort;
        wr_err    = abort;
        wr_idx    = FLD_W'({pin_q, pol_q});
    end

    assign done        = done_q;
    assign timeout_err = to_q;
    assign err_pin     = err_pin_q;

endmodule

// File: rtl/pin_os_seq.sv
// Top of the pin open/short test sequencer. Connects the sequencer, the
// reading classifier, the per-measurement timer and the verdict store.
// Assumes: the force unit holds meas_mv stable in the cycle meas_valid is high.
module pin_os_seq
    import pin_os_pkg::*;
#(
    parameter int NUM_PINS     = 4,
    parameter int MEAS_W       = 16,
    parameter int POS_OPEN_MV  = 1500,
    parameter int POS_SHORT_MV = 200,
    parameter int NEG_SHORT_MV = -200,
    parameter int NEG_OPEN_MV  = -1500,
    parameter int TIMEOUT_CYC  = 32,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_start,
    input  logic                  force_rdy,
    input  logic                  meas_valid,
    input  logic [MEAS_W-1:0]     meas_mv,
    output logic                  busy,
    output logic                  force_req,
    output logic                  force_pol,
    output logic [NUM_PINS-1:0]   pin_sel,
    output logic [NUM_PINS-1:0]   pin_gnd,
    output logic                  rail_gnd,
    output logic                  done,
    output logic                  any_fail,
    output logic                  timeout_err,
    output logic [PIN_W-1:0]      err_pin,
    output logic [4*NUM_PINS-1:0] results
);

    localparam int FLD_W = $clog2(2 * NUM_PINS);

    logic             tmr_clr;
    logic             tmr_run;
    logic             tmr_expired;
    logic             res_clr;
    logic             wr_en;
    logic             wr_err;
    logic [FLD_W-1:0] wr_idx;
    res_code_t        cls_code;
    res_code_t        wr_code;

    pin_os_ctrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .run_start(run_start),
        .force_rdy(force_rdy), .meas_valid(meas_valid),
        .tmr_expired(tmr_expired), .busy(busy), .force_req(force_req),
        .force_pol(force_pol), .pin_sel(pin_sel), .pin_gnd(pin_gnd),
        .rail_gnd(rail_gnd), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
        .res_clr(res_clr), .wr_en(wr_en), .wr_err(wr_err), .wr_idx(wr_idx),
        .done(done), .timeout_err(timeout_err), .err_pin(err_pin)
    );

    pin_os_classify #(
        .MEAS_W(MEAS_W), .POS_OPEN_MV(POS_OPEN_MV), .POS_SHORT_MV(POS_SHORT_MV),
        .NEG_SHORT_MV(NEG_SHORT_MV), .NEG_OPEN_MV(NEG_OPEN_MV)
    ) cls_i (
        .meas_mv(meas_mv), .neg_pol(force_pol), .code(cls_code)
    );

    pin_os_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
        .expired(tmr_expired)
    );

    // Timeouts overwrite the classifier verdict with the error code.
    always_comb wr_code = wr_err ? RES_ERR : cls_code;

    pin_os_results #(.NUM_PINS(NUM_PINS)) res_i (
        .clk(clk), .rst_n(rst_n), .clr(res_clr), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_code(wr_code), .results(results),
        .any_fail(any_fail)
    );

endmodule

// File: rtl/pin_os_seq_chk.sv
// Protocol and status properties of the sequencer, bound to the top.
module pin_os_seq_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  force_req,
    input logic                  force_rdy,
    input logic                  force_pol,
    input logic [NUM_PINS-1:0]   pin_sel,
    input logic [NUM_PINS-1:0]   pin_gnd,
    input logic                  rail_gnd,
    input logic                  done,
    input logic                  any_fail,
    input logic                  timeout_err,
    input logic [4*NUM_PINS-1:0] results
);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones(pin_sel) == 1);

    assert_ground_others_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pin_gnd & pin_sel) == '0 && $countones(pin_gnd) == NUM_PINS - 1 && rail_gnd);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !force_rdy) |=> (force_req && $stable(force_pol) && $stable(pin_sel)) || timeout_err);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !force_req);

    assert_fail_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_fail == (results != '0));

    assert_timeout_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done && !busy && any_fail);

endmodule

bind pin_os_seq pin_os_seq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .force_req(force_req),
    .force_rdy(force_rdy), .force_pol(force_pol), .pin_sel(pin_sel),
    .pin_gnd(pin_gnd), .rail_gnd(rail_gnd), .done(done),
    .any_fail(any_fail), .timeout_err(timeout_err), .results(results)
);

// File: tb/pin_os_seq_tb_top.sv
// Bench: behavioural per-cycle reference model compared on every falling edge.
module pin_os_seq_tb_top;

    localparam int NP    = 4;
    localparam int MW    = 16;
    localparam int TO    = 32;
    localparam int PW    = 2;
    localparam int WDOG  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_start = 1'b0;
    logic          force_rdy = 1'b0;
    logic          meas_valid = 1'b0;
    logic [MW-1:0] meas_mv = '0;
    logic          busy, force_req, force_pol, rail_gnd, done, any_fail, timeout_err;
    logic [NP-1:0] pin_sel, pin_gnd;
    logic [PW-1:0] err_pin;
    logic [4*NP-1:0] results;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pin_os_seq #(.NUM_PINS(NP), .MEAS_W(MW), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .force_rdy(force_rdy),
        .meas_valid(meas_valid), .meas_mv(meas_mv), .busy(busy),
        .force_req(force_req), .force_pol(force_pol), .pin_sel(pin_sel),
        .pin_gnd(pin_gnd), .rail_gnd(rail_gnd), .done(done),
        .any_fail(any_fail), .timeout_err(timeout_err), .err_pin(err_pin),
        .results(results)
    );

    // Verdict rules taken from R3 and R4.
    function automatic int verdict(input int neg, input int mv);
        if (neg == 0) begin
            if (mv > 1500) return 1;
            if (mv < 200)  return 2;
            return 0;
        end
        if (mv > -200)  return 2;
        if (mv < -1500) return 1;
        return 0;
    endfunction

    // Reference model state: phase 0 idle, 1 requesting, 2 awaiting reading.
    int m_ph = 0, m_pin = 0, m_pol = 0, m_tmr = 0;
    int m_done = 0, m_to = 0, m_err = 0;
    int m_res [2*NP];

    // Advance the model on every rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pin = 0; m_pol = 0; m_tmr = 0;
            m_done = 0; m_to = 0; m_err = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            case (m_ph)
                0: if (run_start) begin
                    m_ph = 1; m_pin = 0; m_pol = 0; m_tmr = 0;
                    m_done = 0; m_to = 0; m_err = 0;
                    foreach (m_res[i]) m_res[i] = 0;
                end
                1: begin
                    if (force_rdy) begin m_ph = 2; m_tmr++; end
                    else if (m_tmr >= TO - 1) begin
                        m_res[2*m_pin + m_pol] = 3; m_ph = 0; m_done = 1; m_to = 1; m_err = m_pin;
                    end else m_tmr++;
                end
                default: begin
                    if (meas_valid) begin
                        m_res[2*m_pin + m_pol] = verdict(m_pol, int'($signed(meas_mv)));
                        m_tmr = 0;
                        if (m_pol == 0) begin m_pol = 1; m_ph = 1; end
                        else if (m_pin == NP - 1) begin m_ph = 0; m_done = 1; end
                        else begin m_pin++; m_pol = 0; m_ph = 1; end
                    end else if (m_tmr >= TO - 1) begin
                        m_res[2*m_pin + m_pol] = 3; m_ph = 0; m_done = 1; m_to = 1; m_err = m_pin;
                    end else m_tmr++;
                end
            endcase
        end
    end

    function automatic logic [4*NP-1:0] model_results();
        logic [4*NP-1:0] v = '0;
        for (int i = 0; i < 2*NP; i++) v[2*i +: 2] = 2'(m_res[i]);
        return v;
    endfunction

    function automatic bit model_fail();
        for (int i = 0; i < 2*NP; i++) if (m_res[i] != 0) return 1;
        return 0;
    endfunction

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [NP-1:0] e_sel;
            bit bad = 0;
            e_sel = (m_ph != 0) ? NP'(1) << m_pin : '0;
            if (busy !== (m_ph != 0)) begin bad = 1; $display("FAIL R7 busy act=%b exp=%b", busy, m_ph != 0); end
            if (force_req !== (m_ph == 1)) begin bad = 1; $display("FAIL R5 force_req act=%b exp=%b", force_req, m_ph == 1); end
            if (force_pol !== (m_ph != 0 && m_pol == 1)) begin bad = 1; $display("FAIL R1 force_pol act=%b exp=%b", force_pol, m_ph != 0 && m_pol == 1); end
            if (pin_sel !== e_sel) begin bad = 1; $display("FAIL R1 pin_sel act=%b exp=%b", pin_sel, e_sel); end
            if (pin_gnd !== ~e_sel || rail_gnd !== (m_ph != 0)) begin bad = 1; $display("FAIL R2 pin_gnd/rail act=%b/%b exp=%b/%b", pin_gnd, rail_gnd, ~e_sel, m_ph != 0); end
            if (done !== 1'(m_done)) begin bad = 1; $display("FAIL R7 done act=%b exp=%0d", done, m_done); end
            if (results !== model_results()) begin bad = 1; $display("FAIL R6 results act=%h exp=%h", results, model_results()); end
            if (any_fail !== model_fail()) begin bad = 1; $display("FAIL R8 any_fail act=%b exp=%b", any_fail, model_fail()); end
            if (timeout_err !== 1'(m_to) || (m_to != 0 && err_pin !== PW'(m_err))) begin
                bad = 1; $display("FAIL R9 timeout act=%b/%0d exp=%0d/%0d", timeout_err, err_pin, m_to, m_err);
            end
            vectors++;
            if (bad) misses++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !finished) begin
            finished = 1;
            misses++;
            $display("FAIL watchdog act=%0d cycles exp<%0d", cycles, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_run();
        @(negedge clk); run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
    endtask

    // Serve one measurement; junk > 0 first pulses an early reading (R5).
    task automatic serve(input int rdy_dly, input int val_dly, input int mv, input int junk);
        while (force_req !== 1'b1) @(negedge clk);
        if (junk != 0) begin
            meas_valid = 1'b1; meas_mv = MW'(5000);
            @(negedge clk); meas_valid = 1'b0;
        end
        repeat (rdy_dly) @(negedge clk);
        force_rdy = 1'b1;
        @(negedge clk); force_rdy = 1'b0;
        repeat (val_dly) @(negedge clk);
        meas_valid = 1'b1; meas_mv = MW'(mv);
        @(negedge clk); meas_valid = 1'b0; meas_mv = '0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    int bnd_mv [8] = '{1501, -1500, 1500, -199, 199, -1501, 200, -200};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset results", 32'(results), 32'h0);
        check("R7 reset done/busy", {30'h0, done, busy}, 32'h0);
        check("R2 idle grounds", {27'h0, rail_gnd, pin_gnd}, 32'h0000000F);

        // All healthy diodes.
        start_run();
        for (int p = 0; p < NP; p++) begin
            serve(p, 1, 550, 0);
            serve(0, p + 2, -620, 0);
        end
        wait_done();
        check("R1 healthy run results", 32'(results), 32'h0);
        check("R8 healthy run no fail", 32'(any_fail), 32'h0);

        // Limit values and one millivolt beyond, with an early strobe and a
        // mid-run restart pulse.
        start_run();
        for (int i = 0; i < 2*NP; i++) begin
            serve(i % 3, 1, bnd_mv[i], (i == 3) ? 1 : 0);
            if (i == 4) begin
                @(negedge clk); run_start = 1'b1;
                @(negedge clk); run_start = 1'b0;
            end
        end
        wait_done();
        for (int i = 0; i < 2*NP; i++) begin
            check((i % 2 == 0) ? "R3 positive window" : "R4 negative window",
                  32'(results[2*i +: 2]), 32'(verdict(i % 2, bnd_mv[i])));
        end
        check("R10 restart ignored, early fields kept", 32'(results[1:0]), 32'h1);
        check("R8 boundary run fail", 32'(any_fail), 32'h1);

        // Ready never comes on pin 1 positive.
        start_run();
        check("R6 fields cleared on start", 32'(results), 32'h0);
        serve(0, 0, 600, 0);
        serve(1, 0, -600, 0);
        wait_done();
        check("R9 stall at ready code", 32'(results[5:4]), 32'h3);
        check("R9 stall at ready pin", {29'h0, timeout_err, err_pin}, 32'h5);

        // Reading never comes on pin 0 negative.
        start_run();
        serve(0, 2, 700, 0);
        while (force_req !== 1'b1) @(negedge clk);
        force_rdy = 1'b1; @(negedge clk); force_rdy = 1'b0;
        wait_done();
        check("R9 stall at reading code", 32'(results), 32'h0000000C);
        check("R9 stall at reading flags", {28'h0, busy, any_fail, timeout_err, done}, 32'h7);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule